// File: doc/BRIEF.md
# Two-Level Bus Fabric with IO Width Halving

This block sits between a single 64-bit bus master and the memory and device targets of a small system. A first-stage decoder looks at every request and steers it to one of three targets: block RAM, DRAM or an IO branch. Requests for block RAM and DRAM pass through without any register, so their strobe and acknowledge paths are purely combinational.

IO requests take a slower path. First a register stage captures them, and only one IO transaction may be in flight. A width converter then turns each 64-bit request into one or two 32-bit cycles. A second decoder spreads those narrow cycles over a set of 4 KiB device slots. A 64-bit access that enables bytes in both halves becomes two narrow cycles, low half first. The two read halves are merged and the master sees a single acknowledge.

Addresses that match no target return an error after a fixed, short delay, so the master never waits forever. Masters issue 8-byte aligned addresses (address bits 2:0 zero) and non-zero byte selects. All handshakes are single-beat: the master holds its cycle and strobe until it sees an acknowledge or an error.

Top module: `soc_bus_fabric`

## Requirements
- R1: The first-stage decode selects DRAM when address bit 28 is set. Otherwise it selects block RAM when address bits 31:16 are zero. Otherwise it selects IO when address bits 31:24 equal 0xC0. Block RAM and DRAM are strobed in the same cycle as the master request, and their acknowledge and read data reach the master in the same cycle they arrive.
- R2: IO requests pass through a register stage, so the master acknowledge for an IO access comes no earlier than the third clock edge after the request is presented.
- R3: The IO side carries 32-bit data. The low narrow cycle uses write data bits 31:0 and address bit 2 = 0. The high narrow cycle uses bits 63:32 and address bit 2 = 1. In a read, a half that was not accessed returns zero.
- R4: If the byte selects have bits set in both 7:4 and 3:0, the access becomes two narrow cycles, the low half first. The master receives one merged acknowledge.
- R5: If only one half's byte selects are set, exactly one narrow cycle is issued. For the high half, select bits 7:4 appear on narrow select bits 3:0.
- R6: The device slot is address bits 13:12, and the device index equals the slot number. A narrow cycle strobes only device N_IO-1 or below, and only when address bits 23:14 are zero. At most one device strobe is high at a time.
- R7: A request that matches no first-stage target gets an error one cycle later. No target is strobed for it.
- R8: An IO address with an empty slot, or with address bits 23:14 not zero, gets an error to the master within six cycles. No device is strobed for it.
- R9: A narrow cycle keeps its strobe, address and selects stable until it is acknowledged. Each IO access produces exactly the expected number of device acknowledges.
- R10: While reset is applied and right after it is released, every strobe, the acknowledge and the error output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | 1 | Master cycle valid |
| m_stb_i | input | 1 | Master strobe |
| m_we_i | input | 1 | Master write enable |
| m_adr_i | input | 32 | Master byte address, 8-byte aligned |
| m_dat_i | input | 64 | Master write data |
| m_sel_i | input | 8 | Master byte selects |
| m_dat_o | output | 64 | Read data to master |
| m_ack_o | output | 1 | Acknowledge to master |
| m_err_o | output | 1 | Error to master |
| bram_cyc_o | output | 1 | Block RAM cycle |
| bram_stb_o | output | 1 | Block RAM strobe |
| bram_we_o | output | 1 | Block RAM write enable |
| bram_adr_o | output | 32 | Block RAM address |
| bram_dat_o | output | 64 | Block RAM write data |
| bram_sel_o | output | 8 | Block RAM byte selects |
| bram_dat_i | input | 64 | Block RAM read data |
| bram_ack_i | input | 1 | Block RAM acknowledge |
| dram_cyc_o | output | 1 | DRAM cycle |
| dram_stb_o | output | 1 | DRAM strobe |
| dram_we_o | output | 1 | DRAM write enable |
| dram_adr_o | output | 32 | DRAM address |
| dram_dat_o | output | 64 | DRAM write data |
| dram_sel_o | output | 8 | DRAM byte selects |
| dram_dat_i | input | 64 | DRAM read data |
| dram_ack_i | input | 1 | DRAM acknowledge |
| io_cyc_o | output | N_IO | Per-device cycle |
| io_stb_o | output | N_IO | Per-device strobe |
| io_we_o | output | 1 | Shared narrow write enable |
| io_adr_o | output | 32 | Shared narrow address |
| io_dat_o | output | 32 | Shared narrow write data |
| io_sel_o | output | 4 | Shared narrow byte selects |
| io_dat_i | input | 32*N_IO | Per-device read data, device k at bits 32k+31:32k |
| io_ack_i | input | N_IO | Per-device acknowledge |

## Verification
Suppose the width converter is left in a wrong phase. The write would then land in the other 32-bit half, or a read half would not be zeroed. The port shows this on the next read-back of that location, or as a wrong device acknowledge sequence seen at the device ports when that same access completes. Suppose the register stage or the converter stalls in a busy state. The next IO access then never gets an acknowledge, and the per-access timeout reports it within a hundred cycles. A wrong first- or second-stage decode shows up at once. It appears as a strobe to the wrong port, an error where data was expected, or a device acknowledge count that changed for an access that should have touched nothing.

// File: rtl/bus_fabric_pkg.sv
package bus_fabric_pkg;
  localparam int ADDR_W   = 32;
  localparam int WIDE_W   = 64;
  localparam int NARROW_W = WIDE_W / 2;
  localparam int WSEL_W   = WIDE_W / 8;
  localparam int NSEL_W   = NARROW_W / 8;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_BRAM,
    TGT_DRAM,
    TGT_IO
  } tgt_e;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] adr;
    logic [WIDE_W-1:0] dat;
    logic [WSEL_W-1:0] sel;
  } wide_req_t;
endpackage

// File: rtl/bf_l1_decode.sv
module bf_l1_decode
  import bus_fabric_pkg::*;
#(
  parameter int          BRAM_AW  = 16,
  parameter int          DRAM_BIT = 28,
  parameter int          TAG_W    = 8,
  parameter logic [TAG_W-1:0] IO_TAG = 8'hC0
) (
  input  logic [ADDR_W-1:BRAM_AW] adr_hi_i,
  output tgt_e                    tgt_o
);
  localparam int HI_W = ADDR_W - BRAM_AW;

  always_comb begin
    if (adr_hi_i[DRAM_BIT])
      tgt_o = TGT_DRAM;
    else if (adr_hi_i == '0)
      tgt_o = TGT_BRAM;
    else if (adr_hi_i[ADDR_W-1 -: TAG_W] == IO_TAG)
      tgt_o = TGT_IO;
    else
      tgt_o = TGT_NONE;
  end

  if (HI_W < TAG_W) begin : g_bad_cfg
    initial $display("bf_l1_decode: tag wider than decoded span");
  end
endmodule

// File: rtl/bf_io_slice.sv
module bf_io_slice
  import bus_fabric_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  wide_req_t         req_i,
  input  logic              done_i,
  input  logic              done_err_i,
  input  logic [WIDE_W-1:0] done_dat_i,
  output logic              idle_o,
  output logic              valid_o,
  output wide_req_t         req_o,
  output logic              resp_ack_o,
  output logic              resp_err_o,
  output logic [WIDE_W-1:0] resp_dat_o
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_RESP} slice_st_e;

  slice_st_e         st_q;
  wide_req_t         req_q;
  logic              err_q;
  logic [WIDE_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      req_q <= '0;
      err_q <= 1'b0;
      dat_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (take_i) begin
          req_q <= req_i;
          st_q  <= S_BUSY;
        end
        S_BUSY: if (done_i) begin
          dat_q <= done_dat_i;
          err_q <= done_err_i;
          st_q  <= S_RESP;
        end
        default: st_q <= S_IDLE;  // response pulse lasts one cycle
      endcase
    end
  end

  assign idle_o     = (st_q == S_IDLE);
  assign valid_o    = (st_q == S_BUSY);
  assign req_o      = req_q;
  assign resp_ack_o = (st_q == S_RESP) && !err_q;
  assign resp_err_o = (st_q == S_RESP) && err_q;
  assign resp_dat_o = dat_q;
endmodule

// File: rtl/bf_downsizer.sv
module bf_downsizer
  import bus_fabric_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  wide_req_t           req_i,
  output logic                n_stb_o,
  output logic                n_we_o,
  output logic [ADDR_W-1:0]   n_adr_o,
  output logic [NARROW_W-1:0] n_dat_o,
  output logic [NSEL_W-1:0]   n_sel_o,
  input  logic                n_ack_i,
  input  logic                n_err_i,
  input  logic [NARROW_W-1:0] n_dat_i,
  output logic                done_o,
  output logic                done_err_o,
  output logic [WIDE_W-1:0]   done_dat_o
);
  typedef enum logic [1:0] {D_IDLE, D_LO, D_HI} dsz_st_e;

  dsz_st_e             st_q;
  logic [NARROW_W-1:0] lo_q;
  logic                lo_used, hi_used, in_hi;

  assign lo_used = |req_i.sel[NSEL_W-1:0];
  assign hi_used = |req_i.sel[WSEL_W-1:NSEL_W];
  assign in_hi   = (st_q == D_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= D_IDLE;
      lo_q <= '0;
    end else begin
      unique case (st_q)
        D_IDLE: if (valid_i) st_q <= (hi_used && !lo_used) ? D_HI : D_LO;
        D_LO: begin
          if (n_err_i) st_q <= D_IDLE;
          else if (n_ack_i) begin
            lo_q <= n_dat_i;
            st_q <= hi_used ? D_HI : D_IDLE;
          end
        end
        default: if (n_ack_i || n_err_i) st_q <= D_IDLE;
      endcase
    end
  end

  assign n_stb_o = (st_q != D_IDLE);
  assign n_we_o  = req_i.we;
  assign n_adr_o = {req_i.adr[ADDR_W-1:3], req_i.adr[2] | in_hi, req_i.adr[1:0]};
  assign n_dat_o = in_hi ? req_i.dat[WIDE_W-1:NARROW_W] : req_i.dat[NARROW_W-1:0];
  assign n_sel_o = in_hi ? req_i.sel[WSEL_W-1:NSEL_W] : req_i.sel[NSEL_W-1:0];

  always_comb begin
    done_o     = 1'b0;
    done_dat_o = '0;
    if (st_q == D_LO) begin
      done_o     = n_err_i || (n_ack_i && !hi_used);
      done_dat_o = {{NARROW_W{1'b0}}, n_dat_i};
    end else if (in_hi) begin
      done_o     = n_err_i || n_ack_i;
      done_dat_o = {n_dat_i, lo_used ? lo_q : {NARROW_W{1'b0}}};
    end
  end
  assign done_err_o = n_err_i;
endmodule

// File: rtl/bf_io_decode.sv
module bf_io_decode
  import bus_fabric_pkg::*;
#(
  parameter int N_IO     = 3,
  parameter int SLOT_LSB = 12,
  parameter int SLOT_W   = 2,
  parameter int TAG_W    = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     stb_i,
  input  logic [ADDR_W-TAG_W-1:SLOT_LSB] adr_i,
  output logic                     ack_o,
  output logic                     err_o,
  output logic [NARROW_W-1:0]      dat_o,
  output logic [N_IO-1:0]          dev_stb_o,
  input  logic [N_IO-1:0]          dev_ack_i,
  input  logic [N_IO*NARROW_W-1:0] dev_dat_i
);
  localparam int SPAN_LSB = SLOT_LSB + SLOT_W;

  logic [SLOT_W-1:0] slot;
  logic              mapped;
  logic              err_q;

  assign slot   = adr_i[SLOT_LSB +: SLOT_W];
  assign mapped = (adr_i[ADDR_W-TAG_W-1:SPAN_LSB] == '0) && (int'(slot) < N_IO);

  for (genvar g = 0; g < N_IO; g++) begin : g_dev
    assign dev_stb_o[g] = stb_i && mapped && (slot == SLOT_W'(g));
  end

  always_comb begin
    dat_o = '0;
    for (int k = 0; k < N_IO; k++)
      if (slot == SLOT_W'(k)) dat_o = dev_dat_i[k*NARROW_W +: NARROW_W];
  end

  assign ack_o = |(dev_ack_i & dev_stb_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= stb_i && !mapped && !err_q;
  end
  assign err_o = err_q;
endmodule

// File: rtl/soc_bus_fabric.sv
module soc_bus_fabric
  import bus_fabric_pkg::*;
#(
  parameter int N_IO     = 3,
  parameter int BRAM_AW  = 16,
  parameter int DRAM_BIT = 28,
  parameter int SLOT_LSB = 12,
  parameter int SLOT_W   = 2,
  parameter int TAG_W    = 8,
  parameter logic [TAG_W-1:0] IO_TAG = 8'hC0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     m_cyc_i,
  input  logic                     m_stb_i,
  input  logic                     m_we_i,
  input  logic [ADDR_W-1:0]        m_adr_i,
  input  logic [WIDE_W-1:0]        m_dat_i,
  input  logic [WSEL_W-1:0]        m_sel_i,
  output logic [WIDE_W-1:0]        m_dat_o,
  output logic                     m_ack_o,
  output logic                     m_err_o,
  output logic                     bram_cyc_o,
  output logic                     bram_stb_o,
  output logic                     bram_we_o,
  output logic [ADDR_W-1:0]        bram_adr_o,
  output logic [WIDE_W-1:0]        bram_dat_o,
  output logic [WSEL_W-1:0]        bram_sel_o,
  input  logic [WIDE_W-1:0]        bram_dat_i,
  input  logic                     bram_ack_i,
  output logic                     dram_cyc_o,
  output logic                     dram_stb_o,
  output logic                     dram_we_o,
  output logic [ADDR_W-1:0]        dram_adr_o,
  output logic [WIDE_W-1:0]        dram_dat_o,
  output logic [WSEL_W-1:0]        dram_sel_o,
  input  logic [WIDE_W-1:0]        dram_dat_i,
  input  logic                     dram_ack_i,
  output logic [N_IO-1:0]          io_cyc_o,
  output logic [N_IO-1:0]          io_stb_o,
  output logic                     io_we_o,
  output logic [ADDR_W-1:0]        io_adr_o,
  output logic [NARROW_W-1:0]      io_dat_o,
  output logic [NSEL_W-1:0]        io_sel_o,
  input  logic [N_IO*NARROW_W-1:0] io_dat_i,
  input  logic [N_IO-1:0]          io_ack_i
);
  tgt_e              tgt;
  logic              req, l1_err_q;
  logic              slice_idle, slice_valid, io_take;
  wide_req_t         m_req, io_req;
  logic              resp_ack, resp_err;
  logic [WIDE_W-1:0] resp_dat;
  logic              n_stb, n_ack, n_err, done, done_err;
  logic [NARROW_W-1:0] n_rdat;
  logic [WIDE_W-1:0] done_dat;

  assign req = m_cyc_i && m_stb_i;

  bf_l1_decode #(
    .BRAM_AW (BRAM_AW),
    .DRAM_BIT(DRAM_BIT),
    .TAG_W   (TAG_W),
    .IO_TAG  (IO_TAG)
  ) u_l1_dec (
    .adr_hi_i(m_adr_i[ADDR_W-1:BRAM_AW]),
    .tgt_o   (tgt)
  );

  // unregistered memory legs
  assign bram_cyc_o = m_cyc_i && (tgt == TGT_BRAM);
  assign bram_stb_o = req && (tgt == TGT_BRAM);
  assign bram_we_o  = m_we_i;
  assign bram_adr_o = m_adr_i;
  assign bram_dat_o = m_dat_i;
  assign bram_sel_o = m_sel_i;

  assign dram_cyc_o = m_cyc_i && (tgt == TGT_DRAM);
  assign dram_stb_o = req && (tgt == TGT_DRAM);
  assign dram_we_o  = m_we_i;
  assign dram_adr_o = m_adr_i;
  assign dram_dat_o = m_dat_i;
  assign dram_sel_o = m_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) l1_err_q <= 1'b0;
    else         l1_err_q <= req && (tgt == TGT_NONE) && !l1_err_q;
  end

  // IO leg
  assign io_take = req && (tgt == TGT_IO) && slice_idle;
  assign m_req   = '{we: m_we_i, adr: m_adr_i, dat: m_dat_i, sel: m_sel_i};

  bf_io_slice u_slice (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (io_take),
    .req_i     (m_req),
    .done_i    (done),
    .done_err_i(done_err),
    .done_dat_i(done_dat),
    .idle_o    (slice_idle),
    .valid_o   (slice_valid),
    .req_o     (io_req),
    .resp_ack_o(resp_ack),
    .resp_err_o(resp_err),
    .resp_dat_o(resp_dat)
  );

  bf_downsizer u_dsz (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (slice_valid),
    .req_i     (io_req),
    .n_stb_o   (n_stb),
    .n_we_o    (io_we_o),
    .n_adr_o   (io_adr_o),
    .n_dat_o   (io_dat_o),
    .n_sel_o   (io_sel_o),
    .n_ack_i   (n_ack),
    .n_err_i   (n_err),
    .n_dat_i   (n_rdat),
    .done_o    (done),
    .done_err_o(done_err),
    .done_dat_o(done_dat)
  );

  bf_io_decode #(
    .N_IO    (N_IO),
    .SLOT_LSB(SLOT_LSB),
    .SLOT_W  (SLOT_W),
    .TAG_W   (TAG_W)
  ) u_l2_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (n_stb),
    .adr_i    (io_adr_o[ADDR_W-TAG_W-1:SLOT_LSB]),
    .ack_o    (n_ack),
    .err_o    (n_err),
    .dat_o    (n_rdat),
    .dev_stb_o(io_stb_o),
    .dev_ack_i(io_ack_i),
    .dev_dat_i(io_dat_i)
  );
  assign io_cyc_o = io_stb_o;

  // response merge
  assign m_ack_o = (bram_stb_o && bram_ack_i) || (dram_stb_o && dram_ack_i) || resp_ack;
  assign m_err_o = l1_err_q || resp_err;
  assign m_dat_o = bram_stb_o ? bram_dat_i : (dram_stb_o ? dram_dat_i : resp_dat);
endmodule

// File: rtl/soc_bus_fabric_chk.sv
module soc_bus_fabric_chk
  import bus_fabric_pkg::*;
#(
  parameter int N_IO     = 3,
  parameter int BRAM_AW  = 16,
  parameter int DRAM_BIT = 28,
  parameter int TAG_W    = 8,
  parameter logic [TAG_W-1:0] IO_TAG = 8'hC0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m_cyc_i,
  input logic              m_stb_i,
  input logic [ADDR_W-1:0] m_adr_i,
  input logic              m_ack_o,
  input logic              m_err_o,
  input logic              bram_stb_o,
  input logic              dram_stb_o,
  input logic [N_IO-1:0]   io_stb_o,
  input logic [N_IO-1:0]   io_ack_i,
  input logic [ADDR_W-1:0] io_adr_o,
  input logic [NSEL_W-1:0] io_sel_o
);
  logic unmapped;
  assign unmapped = !m_adr_i[DRAM_BIT] && (m_adr_i[ADDR_W-1:BRAM_AW] != '0)
                    && (m_adr_i[ADDR_W-1 -: TAG_W] != IO_TAG);

  p_dram_route_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i && m_stb_i && m_adr_i[DRAM_BIT]) |-> (dram_stb_o && !bram_stb_o));

  p_io_behind_master_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|io_stb_o) |-> (m_cyc_i && m_stb_i));

  p_resp_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_ack_o && m_err_o));

  p_dev_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(io_stb_o));

  p_unmapped_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i && m_stb_i && unmapped && !m_err_o) |=> m_err_o);

  p_unmapped_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_cyc_i && m_stb_i && unmapped) |-> (!bram_stb_o && !dram_stb_o));

  p_narrow_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|io_stb_o) && !(|(io_stb_o & io_ack_i))) |=>
      ($stable(io_stb_o) && $stable(io_adr_o) && $stable(io_sel_o)));
endmodule

bind soc_bus_fabric soc_bus_fabric_chk #(
  .N_IO    (N_IO),
  .BRAM_AW (BRAM_AW),
  .DRAM_BIT(DRAM_BIT),
  .TAG_W   (TAG_W),
  .IO_TAG  (IO_TAG)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .m_cyc_i   (m_cyc_i),
  .m_stb_i   (m_stb_i),
  .m_adr_i   (m_adr_i),
  .m_ack_o   (m_ack_o),
  .m_err_o   (m_err_o),
  .bram_stb_o(bram_stb_o),
  .dram_stb_o(dram_stb_o),
  .io_stb_o  (io_stb_o),
  .io_ack_i  (io_ack_i),
  .io_adr_o  (io_adr_o),
  .io_sel_o  (io_sel_o)
);

// File: tb/soc_bus_fabric_test.sv
module bf_tb_mem #(parameter int LAT = 0, parameter int DW = 64, parameter int IW = 8)
(
  input  logic            clk, rst_n, stb, we,
  input  logic [31:0]     adr,
  input  logic [DW-1:0]   wdat,
  input  logic [DW/8-1:0] sel,
  output logic [DW-1:0]   rdat,
  output logic            ack,
  output int              acks,
  output logic [3:0]      lhi,
  output logic [15:0]     lsel
);
  localparam int LB = $clog2(DW/8);
  logic [DW-1:0] mem [1<<IW];
  int cnt;
  assign rdat = mem[adr[LB +: IW]];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 0; cnt <= 0; acks <= 0; lhi <= 0; lsel <= 0;
      for (int i = 0; i < (1 << IW); i++) mem[i] <= '0;
    end else if (stb && !ack) begin
      if (cnt == LAT) begin
        ack <= 1; cnt <= 0; acks <= acks + 1;
        lhi[acks % 4] <= adr[2];
        lsel[(acks % 4)*4 +: 4] <= sel[3:0];
        if (we)
          for (int b = 0; b < DW/8; b++)
            if (sel[b]) mem[adr[LB +: IW]][b*8 +: 8] <= wdat[b*8 +: 8];
      end else cnt <= cnt + 1;
    end else begin
      ack <= 0;
      if (!stb) cnt <= 0;
    end
  end
endmodule

module soc_bus_fabric_test;
  localparam int NDEV = 3;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic m_cyc = 0, m_stb = 0, m_we = 0;
  logic [31:0] m_adr = 0;
  logic [63:0] m_wdat = 0;
  logic [7:0]  m_sel = 0;
  logic [63:0] m_rdat;
  logic        m_ack, m_err;
  logic b_cyc, b_stb, b_we, d_cyc, d_stb, d_we, b_ack, d_ack;
  logic [31:0] b_adr, d_adr;
  logic [63:0] b_wd, d_wd, b_rd, d_rd;
  logic [7:0]  b_sel, d_sel;
  logic [NDEV-1:0] io_cyc, io_stb, io_ack;
  logic        io_we;
  logic [31:0] io_adr, io_wd;
  logic [3:0]  io_sel;
  logic [NDEV*32-1:0] io_rd;
  logic [31:0] dev_rd [NDEV];
  int          dev_acks [NDEV];
  logic [3:0]  dev_lhi [NDEV];
  logic [15:0] dev_lsel [NDEV];
  int          b_acks, d_acks;
  logic [3:0]  b_lhi, d_lhi;
  logic [15:0] b_lsel, d_lsel;

  soc_bus_fabric uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
    .m_dat_i(m_wdat), .m_sel_i(m_sel), .m_dat_o(m_rdat), .m_ack_o(m_ack), .m_err_o(m_err),
    .bram_cyc_o(b_cyc), .bram_stb_o(b_stb), .bram_we_o(b_we), .bram_adr_o(b_adr),
    .bram_dat_o(b_wd), .bram_sel_o(b_sel), .bram_dat_i(b_rd), .bram_ack_i(b_ack),
    .dram_cyc_o(d_cyc), .dram_stb_o(d_stb), .dram_we_o(d_we), .dram_adr_o(d_adr),
    .dram_dat_o(d_wd), .dram_sel_o(d_sel), .dram_dat_i(d_rd), .dram_ack_i(d_ack),
    .io_cyc_o(io_cyc), .io_stb_o(io_stb), .io_we_o(io_we), .io_adr_o(io_adr),
    .io_dat_o(io_wd), .io_sel_o(io_sel), .io_dat_i(io_rd), .io_ack_i(io_ack)
  );

  bf_tb_mem #(.LAT(0)) u_bram (.clk(clk), .rst_n(rst_n), .stb(b_stb), .we(b_we), .adr(b_adr),
    .wdat(b_wd), .sel(b_sel), .rdat(b_rd), .ack(b_ack), .acks(b_acks), .lhi(b_lhi), .lsel(b_lsel));
  bf_tb_mem #(.LAT(1)) u_dram (.clk(clk), .rst_n(rst_n), .stb(d_stb), .we(d_we), .adr(d_adr),
    .wdat(d_wd), .sel(d_sel), .rdat(d_rd), .ack(d_ack), .acks(d_acks), .lhi(d_lhi), .lsel(d_lsel));

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    bf_tb_mem #(.LAT(g), .DW(32), .IW(10)) u_dev (.clk(clk), .rst_n(rst_n), .stb(io_stb[g]),
      .we(io_we), .adr(io_adr), .wdat(io_wd), .sel(io_sel), .rdat(dev_rd[g]), .ack(io_ack[g]),
      .acks(dev_acks[g]), .lhi(dev_lhi[g]), .lsel(dev_lsel[g]));
    assign io_rd[g*32 +: 32] = dev_rd[g];
  end

  int n_checks = 0, n_errs = 0;
  logic [63:0] ref_b [256];
  logic [63:0] ref_d [256];
  logic [31:0] ref_io [NDEV][1024];
  logic [63:0] r_dat;
  logic        r_ack, r_err;
  int          r_cyc;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // 0 none, 1 bram, 2 dram, 3 io (R1)
  function automatic int l1_of(input logic [31:0] a);
    if (a[28]) return 2;
    if (a[31:16] == 0) return 1;
    if (a[31:24] == 8'hC0) return 3;
    return 0;
  endfunction

  // device index or -1 when unmapped (R6)
  function automatic int dev_of(input logic [31:0] a);
    if (a[23:14] != 0 || int'(a[13:12]) >= NDEV) return -1;
    return int'(a[13:12]);
  endfunction

  function automatic logic [63:0] merge64(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] s);
    logic [63:0] r = old;
    for (int b = 0; b < 8; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  task automatic bus(input logic we, input logic [31:0] a, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk);
    m_cyc = 1; m_stb = 1; m_we = we; m_adr = a; m_wdat = d; m_sel = s;
    r_cyc = 0; r_ack = 0; r_err = 0; r_dat = 0;
    forever begin
      @(negedge clk);
      r_cyc++;
      if (m_ack || m_err) begin
        r_ack = m_ack; r_err = m_err; r_dat = m_rdat;
        m_cyc = 0; m_stb = 0;
        break;
      end
      if (r_cyc > 100) begin
        m_cyc = 0; m_stb = 0;
        check(0, "R9 timeout", 64'(r_cyc), 64'd100);
        break;
      end
    end
  endtask

  task automatic xfer(input logic we, input logic [31:0] a, input logic [63:0] d, input logic [7:0] s);
    int t = l1_of(a);
    int dv = dev_of(a);
    int b0 = b_acks, d0 = d_acks;
    int da [NDEV];
    for (int k = 0; k < NDEV; k++) da[k] = dev_acks[k];
    bus(we, a, d, s);
    if (t == 0) begin
      check(r_err && !r_ack, "R7 err", {62'd0, r_ack, r_err}, 64'd1);
      check(r_cyc == 1, "R7 err delay", 64'(r_cyc), 64'd1);
      check(b_acks == b0 && d_acks == d0, "R7 no target", 64'(b_acks + d_acks), 64'(b0 + d0));
    end else if (t == 1 || t == 2) begin
      logic [63:0] exp;
      int ix = int'(a[10:3]);
      exp = (t == 1) ? ref_b[ix] : ref_d[ix];
      check(r_ack && !r_err, "R1 ack", {62'd0, r_ack, r_err}, 64'd2);
      check(r_cyc == t, "R1 latency", 64'(r_cyc), 64'(t));
      if (we) begin
        if (t == 1) ref_b[ix] = merge64(exp, d, s); else ref_d[ix] = merge64(exp, d, s);
      end else check(r_dat == exp, "R1 read data", r_dat, exp);
    end else if (dv < 0) begin
      int tot = 0, tot0 = 0;
      for (int k = 0; k < NDEV; k++) begin tot += dev_acks[k]; tot0 += da[k]; end
      check(r_err && !r_ack, "R8 err", {62'd0, r_ack, r_err}, 64'd1);
      check(r_cyc <= 6, "R8 bound", 64'(r_cyc), 64'd6);
      check(tot == tot0, "R8 no device", 64'(tot), 64'(tot0));
    end else begin
      bit lo = |s[3:0], hi = |s[7:4];
      int nexp = int'(lo) + int'(hi);
      int wi = int'({a[11:3], 1'b0});
      logic [63:0] exp = {hi ? ref_io[dv][wi+1] : 32'h0, lo ? ref_io[dv][wi] : 32'h0};
      int e0 = da[dv] % 4, e1 = (da[dv] + 1) % 4;
      check(r_ack && !r_err, "R6 io ack", {62'd0, r_ack, r_err}, 64'd2);
      check(r_cyc >= 3, "R2 registered", 64'(r_cyc), 64'd3);
      check(dev_acks[dv] - da[dv] == nexp, "R9 device acks", 64'(dev_acks[dv] - da[dv]), 64'(nexp));
      if (lo && hi) begin
        check(dev_lhi[dv][e0] == 0 && dev_lhi[dv][e1] == 1, "R4 low first",
              {62'd0, dev_lhi[dv][e0], dev_lhi[dv][e1]}, 64'd1);
        check(dev_lsel[dv][e0*4 +: 4] == s[3:0] && dev_lsel[dv][e1*4 +: 4] == s[7:4], "R4 sels",
              {56'd0, dev_lsel[dv][e1*4 +: 4], dev_lsel[dv][e0*4 +: 4]}, {56'd0, s});
      end else begin
        check(dev_lhi[dv][e0] == hi, "R5 half", 64'(dev_lhi[dv][e0]), 64'(hi));
        check(dev_lsel[dv][e0*4 +: 4] == (hi ? s[7:4] : s[3:0]), "R5 shifted sel",
              64'(dev_lsel[dv][e0*4 +: 4]), 64'(hi ? s[7:4] : s[3:0]));
      end
      if (we) begin
        logic [63:0] m = merge64({ref_io[dv][wi+1], ref_io[dv][wi]}, d, s);
        ref_io[dv][wi] = m[31:0]; ref_io[dv][wi+1] = m[63:32];
      end else check(r_dat == exp, "R3 read merge", r_dat, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_errs++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin ref_b[i] = 0; ref_d[i] = 0; end
    for (int k = 0; k < NDEV; k++) for (int i = 0; i < 1024; i++) ref_io[k][i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!m_ack && !m_err && !b_stb && !d_stb && io_stb == 0, "R10 in reset",
          {59'd0, m_ack, m_err, b_stb, d_stb, |io_stb}, 64'd0);
    rst_n = 1;
    @(negedge clk);
    check(!m_ack && !m_err && !b_stb && !d_stb && io_stb == 0, "R10 after reset",
          {59'd0, m_ack, m_err, b_stb, d_stb, |io_stb}, 64'd0);

    // directed corner cases
    xfer(1, 32'h0000_FFF8, 64'h1111_2222_3333_4444, 8'hFF);  // R1 top of block RAM
    xfer(0, 32'h0000_FFF8, 0, 8'hFF);
    xfer(0, 32'h0001_0000, 0, 8'hFF);                        // R7 just above block RAM
    xfer(1, 32'hD000_0008, 64'hAAAA_BBBB_CCCC_DDDD, 8'hFF);  // R1 bit 28 wins over top byte
    xfer(0, 32'h1000_0008, 0, 8'hFF);
    xfer(1, 32'hC000_2010, 64'h0102_0304_0506_0708, 8'hFF); // R4 split on slowest device
    xfer(0, 32'hC000_2010, 0, 8'hFF);
    xfer(1, 32'hC000_0018, 64'hDEAD_BEEF_CAFE_F00D, 8'h18); // R4 bytes 3 and 4
    xfer(0, 32'hC000_0018, 0, 8'h0F);                        // R5 low only
    xfer(0, 32'hC000_0018, 0, 8'hF0);                        // R5 high only
    xfer(1, 32'hC000_1020, 64'h5555_6666_7777_8888, 8'hC0); // R5 high write
    xfer(0, 32'hC000_1020, 0, 8'hFF);
    xfer(0, 32'hC000_3000, 0, 8'hFF);                        // R8 empty slot
    xfer(1, 32'hC001_0000, 64'h1, 8'h01);                    // R8 stray upper bits
    xfer(0, 32'hC000_0018, 0, 8'hFF);                        // R8 path left no damage

    for (int n = 0; n < 400; n++) begin
      int cls = int'($urandom_range(0, 4));
      logic [31:0] a;
      logic [7:0]  s = 8'($urandom_range(1, 255));
      logic [63:0] d = {$urandom, $urandom};
      logic        we = 1'($urandom_range(0, 1));
      logic [2:0]  ix = 3'($urandom_range(0, 7));
      case (cls)
        0: a = {26'd0, ix, 3'd0};
        1: a = 32'h1000_0000 | {26'd0, ix, 3'd0};
        2, 3: a = 32'hC000_0000 | (32'($urandom_range(0, 3)) << 12) | {26'd0, ix, 3'd0};
        default: a = 32'h4000_0000 | {26'd0, ix, 3'd0};
      endcase
      xfer(we, a, d, s);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule